// File: doc/BRIEF.md
# Guaranteed-Service Link Output Port with Per-Circuit Credits

This block is one output port of an on-chip router that carries guaranteed-service traffic. Flits arrive from a crossbar that was set up once at start-up. Each flit carries no header; the index of its virtual circuit travels beside it. Every circuit owns a small private buffer that sits after the crossbar, and no circuit ever writes into another circuit's buffer. A link arbiter then picks one buffered flit per cycle for the shared outgoing link. It tags that flit with its circuit index so the next router can steer it into the matching buffer.

Each circuit has a credit counter that tracks the free slots in the matching buffer of the downstream router. A circuit can be chosen only when its buffer holds a flit and its counter is above zero. The lowest-numbered circuits carry guaranteed service and share the link in round-robin order. The highest-numbered circuit is the best-effort lane and gets the link only when no guaranteed circuit can send. The link is work conserving: a cycle is never left idle while some circuit could send.

Both data interfaces use valid/ready. On the input side, `in_ready` shows whether the buffer of the circuit named by `in_vc` has room, and a flit is taken when `in_valid` and `in_ready` are both high at a clock edge. A well-behaved crossbar never offers a flit to a full buffer, because upstream credits prevent it. If it does, the flit is dropped and a sticky error flag is raised. On the output side, once `out_valid` is high, the flit, its circuit index and `out_valid` itself stay unchanged until `out_ready` is seen high at a clock edge. This holds even if a higher-priority circuit becomes ready in the meantime.

Top module: `vc_link_port`

## Requirements
- R1: After reset, `out_valid` is 0, `err_overflow` is 0, `in_ready` is 1 for every circuit, and every credit counter holds CREDITS (default 2).
- R2: Each circuit buffer holds BUF_DEPTH flits (default 2) and releases them in arrival order. `in_ready` is 0 exactly when the buffer selected by `in_vc` is full, and the fill state of one circuit does not affect `in_ready` for another.
- R3: A flit of circuit v is offered on the link only while its credit count is above zero. Each accepted link transfer of circuit v lowers that count by one, so with no credit return at most CREDITS flits of v leave.
- R4: A one-cycle pulse on bit v of `credit_ret` adds one credit to circuit v. The credit can be used from the next cycle.
- R5: Guaranteed circuits 0 to NUM_VC-2 that are eligible are served in round-robin order. The search starts at the circuit after the last guaranteed circuit sent, and wraps from NUM_VC-2 to 0. Circuit 0 is searched first after reset.
- R6: The best-effort circuit (index NUM_VC-1, default 7) is offered only when no guaranteed circuit is eligible.
- R7: Whenever any circuit has a buffered flit and a credit, `out_valid` is 1 in that same cycle.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_vc` and `out_data` keep their values into the next cycle.
- R9: When `in_valid` is 1 and the selected buffer is full, the flit is discarded and `err_overflow` becomes 1 and stays 1 until reset.
- R10: A flit accepted at a clock edge into an empty, credited circuit, with the link otherwise idle, appears on `out_data` in the cycle that follows that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Crossbar offers a flit |
| in_ready | output | 1 | Buffer of circuit `in_vc` has room |
| in_vc | input | $clog2(NUM_VC) | Circuit index of the offered flit |
| in_data | input | FLIT_W | Flit payload |
| out_valid | output | 1 | A flit is offered on the link |
| out_ready | input | 1 | Link takes the offered flit |
| out_vc | output | $clog2(NUM_VC) | Circuit index of the offered flit |
| out_data | output | FLIT_W | Offered flit payload |
| credit_ret | input | NUM_VC | One-cycle credit return pulse per circuit |
| err_overflow | output | 1 | Sticky flag: flit offered to a full buffer |

## Verification
A credit counter that is off by one shows as a flit leaving when the downstream buffer is full, or as a circuit that stalls with data buffered. This is seen at `out_valid` in the first cycle after the faulty count, so the bench drains each circuit to zero credits and then returns credits one at a time. A round-robin pointer that is wrong shows as a permuted order of `out_vc` within one round of pending circuits, so the bench loads several circuit masks with different pointer starting positions. A buffer pointer that is wrong shows as a duplicated or reordered payload on the next pop, and a lost hold shows as `out_vc` changing while the link stalls.

// File: rtl/vcp_pkg.sv
package vcp_pkg;
  localparam int unsigned DEF_NUM_VC    = 8;
  localparam int unsigned DEF_FLIT_W    = 32;
  localparam int unsigned DEF_BUF_DEPTH = 2;
  localparam int unsigned DEF_CREDITS   = 2;
endpackage

// File: rtl/vcp_fifo.sv
module vcp_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_en) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (rd_en) rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
  end

  assign rd_data = mem[rp];
  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full); // R9
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !empty); // R2
endmodule

// File: rtl/vcp_credit.sv
module vcp_credit #(
  parameter int unsigned INIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic give,
  output logic avail
);
  localparam int unsigned CW = $clog2(INIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= CW'(INIT);
    else begin
      case ({take, give})
        2'b10:   cnt <= cnt - 1'b1;
        2'b01:   cnt <= cnt + 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign avail = (cnt != '0);

  AST_CREDIT_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> cnt != '0); // R3
  AST_CREDIT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (give && !take) |-> cnt < CW'(INIT)); // R4
endmodule

// File: rtl/vcp_arbiter.sv
module vcp_arbiter #(
  parameter int unsigned NUM_VC = 8,
  localparam int unsigned VW    = $clog2(NUM_VC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_VC-1:0] elig,
  input  logic              xfer,
  input  logic [VW-1:0]     sent_vc,
  output logic              grant_valid,
  output logic [VW-1:0]     grant_vc
);
  localparam int unsigned G  = NUM_VC - 1;
  localparam logic [VW-1:0] BE = VW'(NUM_VC - 1);
  localparam logic [VW-1:0] GL = VW'(G - 1);

  logic [VW-1:0] last_q, ptr;
  logic          found;

  assign ptr = (last_q == GL) ? '0 : last_q + 1'b1;

  always_comb begin
    int idx;
    found    = 1'b0;
    grant_vc = BE;
    for (int k = 0; k < int'(G); k++) begin
      idx = int'(ptr) + k;
      if (idx >= int'(G)) idx = idx - int'(G);
      if (!found && elig[idx]) begin
        found    = 1'b1;
        grant_vc = VW'(idx);
      end
    end
    grant_valid = found || elig[BE];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= GL;
    else if (xfer && sent_vc != BE) last_q <= sent_vc;
  end

  AST_BE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && grant_vc == BE) |-> elig[G-1:0] == '0); // R6
  AST_WORK_CONS: assert property (@(posedge clk) disable iff (!rst_n)
    (|elig) |-> grant_valid); // R7
  AST_GRANT_ELIG: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> elig[grant_vc]); // R3
endmodule

// File: rtl/vc_link_port.sv
module vc_link_port
  import vcp_pkg::*;
#(
  parameter int unsigned NUM_VC    = DEF_NUM_VC,
  parameter int unsigned FLIT_W    = DEF_FLIT_W,
  parameter int unsigned BUF_DEPTH = DEF_BUF_DEPTH,
  parameter int unsigned CREDITS   = DEF_CREDITS,
  localparam int unsigned VW       = $clog2(NUM_VC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [VW-1:0]     in_vc,
  input  logic [FLIT_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [VW-1:0]     out_vc,
  output logic [FLIT_W-1:0] out_data,
  input  logic [NUM_VC-1:0] credit_ret,
  output logic              err_overflow
);
  logic [NUM_VC-1:0] wr_en, rd_en, empty, full, avail, elig;
  logic [FLIT_W-1:0] head [NUM_VC];
  logic              arb_valid, xfer;
  logic [VW-1:0]     arb_vc;
  logic              hold_q;
  logic [VW-1:0]     hold_vc_q;
  logic              err_q;

  assign xfer = out_valid && out_ready;

  for (genvar v = 0; v < int'(NUM_VC); v++) begin : g_vc
    assign wr_en[v] = in_valid && (in_vc == VW'(v)) && !full[v];
    assign rd_en[v] = xfer && (out_vc == VW'(v));
    assign elig[v]  = !empty[v] && avail[v];

    vcp_fifo #(.W(FLIT_W), .DEPTH(BUF_DEPTH)) u_buf (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en[v]), .wr_data(in_data),
      .rd_en(rd_en[v]), .rd_data(head[v]),
      .empty(empty[v]), .full(full[v])
    );

    vcp_credit #(.INIT(CREDITS)) u_cred (
      .clk(clk), .rst_n(rst_n),
      .take(rd_en[v]), .give(credit_ret[v]),
      .avail(avail[v])
    );
  end

  vcp_arbiter #(.NUM_VC(NUM_VC)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .elig(elig), .xfer(xfer), .sent_vc(out_vc),
    .grant_valid(arb_valid), .grant_vc(arb_vc)
  );

  assign in_ready  = !full[in_vc];
  assign out_valid = hold_q || arb_valid;
  assign out_vc    = hold_q ? hold_vc_q : arb_vc;
  assign out_data  = head[out_vc];
  assign err_overflow = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= 1'b0;
      hold_vc_q <= '0;
      err_q     <= 1'b0;
    end else begin
      hold_q    <= out_valid && !out_ready;
      hold_vc_q <= out_vc;
      if (in_valid && full[in_vc]) err_q <= 1'b1;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_vc) && $stable(out_data))); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_overflow |=> err_overflow); // R9
  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> err_overflow); // R9
endmodule

// File: tb/sim_vc_link_port.sv
module sim_vc_link_port;
  localparam int NV = 8;
  localparam int W  = 32;
  localparam int BE = NV - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [2:0]    in_vc = '0;
  logic [W-1:0]  in_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [2:0]    out_vc;
  logic [W-1:0]  out_data;
  logic [NV-1:0] credit_ret = '0;
  logic          err_overflow;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  int last_gs = BE - 1;

  vc_link_port #(.NUM_VC(NV), .FLIT_W(W), .BUF_DEPTH(2), .CREDITS(2)) u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_vc(in_vc), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_vc(out_vc), .out_data(out_data),
    .credit_ret(credit_ret), .err_overflow(err_overflow)
  );

  always #10 clk = ~clk;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pat(int rnd, int vc, int k);
    return 32'hA000_0000 | W'(rnd << 16) | W'(vc << 8) | W'(k);
  endfunction

  function automatic int rr_pick(logic [NV-1:0] m, int last);
    for (int k = 1; k <= BE; k++) begin
      if (m[(last + k) % BE]) return (last + k) % BE;
    end
    return BE;
  endfunction

  // all tasks start and end at a falling edge
  task automatic push(int vc, logic [W-1:0] d);
    in_valid = 1'b1; in_vc = 3'(vc); in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pop_chk(int vc, logic [W-1:0] d, string tag);
    out_ready = 1'b1;
    check({tag, " valid"}, 64'(out_valid), 64'd1);
    check({tag, " vc"}, 64'(out_vc), 64'(vc));
    check({tag, " data"}, 64'(out_data), 64'(d));
    @(negedge clk);
    out_ready = 1'b0;
    if (vc != BE) last_gs = vc;
  endtask

  task automatic ret(int vc);
    credit_ret = NV'(1) << vc;
    @(negedge clk);
    credit_ret = '0;
  endtask

  task automatic rr_round(int rnd, logic [NV-1:0] mask);
    logic [NV-1:0] m;
    int first, e;
    first = -1;
    for (int v = 0; v < NV; v++) begin
      if (mask[v]) begin
        if (first < 0) first = v;
        push(v, pat(rnd, v, 0));
      end
    end
    m = mask;
    pop_chk(first, pat(rnd, first, 0), "R8 held first");
    m[first] = 1'b0;
    while (m != '0) begin
      e = rr_pick(m, last_gs);
      pop_chk(e, pat(rnd, e, 0), (e == BE) ? "R6 best-effort last" : "R5 round-robin");
      m[e] = 1'b0;
    end
    check("R7 idle after round", 64'(out_valid), 64'd0);
    for (int v = 0; v < NV; v++) if (mask[v]) ret(v);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid", 64'(out_valid), 64'd0);
    check("R1 err", 64'(err_overflow), 64'd0);
    for (int v = 0; v < NV; v++) begin
      in_vc = 3'(v);
      #1 check("R1 in_ready", 64'(in_ready), 64'd1);
    end
    @(negedge clk);

    // per-circuit sweep: order, fullness, credit exhaustion and return
    for (int v = 0; v < NV; v++) begin
      push(v, pat(1, v, 0));
      check("R10 next-cycle valid", 64'(out_valid), 64'd1);
      check("R10 next-cycle vc", 64'(out_vc), 64'(v));
      push(v, pat(1, v, 1));
      in_vc = 3'(v);
      #1 check("R2 full drops ready", 64'(in_ready), 64'd0);
      in_vc = 3'((v + 1) % NV);
      #1 check("R2 other circuit ready", 64'(in_ready), 64'd1);
      pop_chk(v, pat(1, v, 0), "R2 order first");
      pop_chk(v, pat(1, v, 1), "R2 order second");
      push(v, pat(1, v, 2));
      check("R3 no credit blocks", 64'(out_valid), 64'd0);
      ret(v);
      check("R4 credit return enables", 64'(out_valid), 64'd1);
      pop_chk(v, pat(1, v, 2), "R4 after return");
      check("R3 one credit used", 64'(out_valid), 64'd0);
      ret(v);
      ret(v);
      check("R2 buffer drained", 64'(out_valid), 64'd0);
    end

    rr_round(2, 8'hFF);
    rr_round(3, 8'hAA);
    rr_round(4, 8'h51);
    rr_round(5, 8'h80);
    rr_round(6, 8'h24);
    rr_round(7, 8'h7E);

    // hold beats priority
    push(BE, pat(8, BE, 0));
    check("R6 best-effort alone", 64'(out_vc), 64'(BE));
    @(negedge clk);
    check("R8 stall vc", 64'(out_vc), 64'(BE));
    push(2, pat(8, 2, 0));
    check("R8 stall keeps vc", 64'(out_vc), 64'(BE));
    check("R8 stall keeps data", 64'(out_data), 64'(pat(8, BE, 0)));
    pop_chk(BE, pat(8, BE, 0), "R8 held released");
    pop_chk(2, pat(8, 2, 0), "R5 after hold");
    ret(BE);
    ret(2);

    // overflow error
    push(0, pat(9, 0, 0));
    push(0, pat(9, 0, 1));
    check("R9 no error yet", 64'(err_overflow), 64'd0);
    push(0, pat(9, 0, 2));
    check("R9 error set", 64'(err_overflow), 64'd1);
    repeat (3) @(negedge clk);
    check("R9 error sticky", 64'(err_overflow), 64'd1);
    pop_chk(0, pat(9, 0, 0), "R9 kept first");
    pop_chk(0, pat(9, 0, 1), "R9 kept second");
    ret(0);
    ret(0);
    check("R9 flit discarded", 64'(out_valid), 64'd0);
    check("R9 error still set", 64'(err_overflow), 64'd1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule